// File: doc/BRIEF.md
# SPI Transmit/Receive Word Buffer

This block sits between a host register bus and a serial shift engine. The host deposits outgoing words into a transmit store. The store is either one holding register or a small FIFO, selected by a parameter. The shift engine takes a word from the store at the start of each transfer. At the end of each transfer it hands back the received word, which lands in a receive store that is double-buffered (a FIFO of depth one or more). The block also answers bus accesses that cannot be served with an error, and keeps a sticky receive-overrun interrupt.

A two-state sequencer decides when a word is handed to the shift engine:

- **IDLE**: no transfer is running.
  - Transition **IDLE→SHIFT (start)**: taken when the go condition holds and a word is available. Go is the enable input in master mode and the slave-select input in slave mode. The word is presented in the same cycle.
- **SHIFT**: a transfer is running.
  - Transition **SHIFT→SHIFT (hold)**: taken in any cycle without a completion.
  - Transition **SHIFT→SHIFT (chain)**: taken on a completion when go still holds and another word is available. The next word is loaded in that same cycle.
  - Transition **SHIFT→IDLE (stop)**: taken on a completion when there is no chain.

Host addresses are decoded as follows:

| Address | Register |
|---------|----------|
| 0 | transmit data |
| 1 | receive data |
| 2 | status |
| 3 | unused |

Top module: `spi_xfer_buffer`

## Requirements
- R1: The word width W is a parameter (8, 16 or 32). On the 32-bit host bus a data word occupies bits [31:32-W], with the word's MSB at bit 31. Received words read back with all lower bits zero.
- R2: After a synchronous active-high reset both stores are empty, the overrun flag is clear, the sequencer is in IDLE and the status register reads 0x0A.
- R3: In IDLE, shift_load pulses in the same cycle in which go holds and a word is available; no load happens while go is low. Go is eng_enable when eng_master=1 and eng_ssel when eng_master=0. A word is available always with the single register, and when the FIFO is non-empty in FIFO mode.
- R4: In SHIFT, an eng_done pulse loads the next word in the same cycle if go holds and a word is available (chain). Otherwise the sequencer returns to IDLE without a load.
- R5: Single-register mode: a host write marks the register full, and a load clears that mark. The stored word is kept and sent again on every later load until the host writes a new one.
- R6: FIFO mode: the head entry is the word presented at a start. Occupancy drops by one only at each completed transfer. A chained load presents the entry after the head.
- R7: A host write to address 0 while the transmit store is full returns host_err=1 and leaves the stored words unchanged.
- R8: A host read of address 0 returns zero with no error.
- R9: At a completed transfer the received word is stored only if the receive store is not full. Otherwise it is discarded and the overrun flag is set.
- R10: A host read of address 1 when the receive store is empty returns zero with host_err=1. A host write to address 1 has no effect and no error.
- R11: The overrun flag drives overrun_irq and stays set until a host write to address 2 with bit 4 set. A write with bit 4 clear leaves it set, and a new overrun in the same cycle as a clear wins.
- R12: The status register has these fields: bit 0 transmit full, bit 1 transmit empty, bit 2 receive full, bit 3 receive empty, bit 4 overrun. All other bits read zero.
- R13: An eng_done pulse in IDLE is ignored: no word is stored and no flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register select (0 tx data, 1 rx data, 2 status, 3 unused) |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Always 1: every access completes in its own cycle |
| host_rdata | output | 32 | Read data, valid in the access cycle |
| host_err | output | 1 | Error response for the access in this cycle |
| eng_master | input | 1 | 1 = master mode, 0 = slave mode |
| eng_enable | input | 1 | Transfer enable used in master mode |
| eng_ssel | input | 1 | Slave select active (high) used in slave mode |
| eng_done | input | 1 | Pulse: shift engine completed a transfer |
| eng_rx_word | input | W | Word received by the completed transfer |
| shift_load | output | 1 | Pulse: shift engine should take shift_word now |
| shift_word | output | W | Word handed to the shift engine |
| overrun_irq | output | 1 | Sticky receive overrun interrupt |

## Verification
Two results are combinational and belong to the cycle of their stimulus: the host response (read data and error) and a load together with its word. The bench raises its inputs at the falling edge and samples these outputs 1 ns later, before the rising edge. The store flags, status contents and overrun interrupt change only at the rising edge that ends the access or completion. The bench therefore reads them one cycle later, either by a following status read or by sampling overrun_irq 1 ns after that edge. Expected words follow from the order in which words were written and completions were pulsed, counted in the bench.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    typedef enum logic [1:0] {
        REG_TXDATA = 2'd0,
        REG_RXDATA = 2'd1,
        REG_STATUS = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_e;

    localparam int STAT_TX_FULL  = 0;
    localparam int STAT_TX_EMPTY = 1;
    localparam int STAT_RX_FULL  = 2;
    localparam int STAT_RX_EMPTY = 3;
    localparam int STAT_OVR      = 4;

    localparam int BUS_W = 32;

endpackage

// File: rtl/spi_buf_fifo.sv
module spi_buf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [W-1:0]                 second,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int MEM_N = 1 << PTR_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [MEM_N];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign second  = mem[step(rd_ptr)];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy rises by exactly one on an accepted lone push
    a_r6_count_up: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));

    // R7: a push into a full store leaves the occupancy unchanged
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    // R6: occupancy falls by one on a lone pop of a non-empty store
    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/spi_buf_seq.sv
module spi_buf_seq
    import spi_buf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic avail_now,
    input  logic avail_next,
    input  logic done,
    output logic load,
    output logic load_next,
    output logic xfer_ok
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go && avail_now) state_d = ST_SHIFT;
            ST_SHIFT: if (done && !(go && avail_next)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load      = 1'b0;
        load_next = 1'b0;
        xfer_ok   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = go && avail_now;
            end
            ST_SHIFT: begin
                xfer_ok   = done;
                load      = done && go && avail_next;
                load_next = done && go && avail_next;
            end
            default: ;
        endcase
    end

    // R3: no word is handed over unless the go condition holds
    a_r3_load_needs_go: assert property (@(posedge clk) disable iff (rst)
        load |-> go);

    // R4: a running transfer without completion stays running, no load
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT && !done) |-> !load ##1 (state_q == ST_SHIFT));

    // R4: a chained load keeps the sequencer in SHIFT
    a_r4_chain: assert property (@(posedge clk) disable iff (rst)
        load_next |=> (state_q == ST_SHIFT));

    // R13: a completion seen in IDLE never counts as a transfer
    a_r13_idle_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !xfer_ok);

endmodule

// File: rtl/spi_xfer_buffer.sv
module spi_xfer_buffer
    import spi_buf_pkg::*;
#(
    parameter int W        = 8,
    parameter int TX_DEPTH = 1,
    parameter int RX_DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_valid,
    input  logic         host_write,
    input  logic [1:0]   host_addr,
    input  logic [31:0]  host_wdata,
    output logic         host_ready,
    output logic [31:0]  host_rdata,
    output logic         host_err,
    input  logic         eng_master,
    input  logic         eng_enable,
    input  logic         eng_ssel,
    input  logic         eng_done,
    input  logic [W-1:0] eng_rx_word,
    output logic         shift_load,
    output logic [W-1:0] shift_word,
    output logic         overrun_irq
);
    localparam int PAD_W    = BUS_W - W;
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);

    reg_sel_e     sel;
    logic         go;
    logic         wr_tx, wr_st, rd_rx;
    logic [W-1:0] wr_word;
    logic         tx_full, tx_empty, tx_avail_now, tx_avail_next, tx_push;
    logic [W-1:0] tx_word_now, tx_word_next;
    logic         load_next, xfer_ok;
    logic         rx_full, rx_empty;
    logic [W-1:0] rx_head, rx_second;
    logic [RX_CNT_W-1:0] rx_count;
    logic         ovr_q, ovr_set, ovr_clr;
    logic [BUS_W-1:0] status;
    logic         unused_bits;

    assign sel     = reg_sel_e'(host_addr);
    assign go      = eng_master ? eng_enable : eng_ssel;
    assign wr_tx   = host_valid && host_write && (sel == REG_TXDATA);
    assign wr_st   = host_valid && host_write && (sel == REG_STATUS);
    assign rd_rx   = host_valid && !host_write && (sel == REG_RXDATA);
    assign wr_word = host_wdata[BUS_W-1 -: W];
    assign tx_push = wr_tx && !tx_full;

    // transmit store: single holding register or FIFO
    generate
        if (TX_DEPTH == 1) begin : g_tx_reg
            logic [W-1:0] hold_q;
            logic         pend_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= '0;
                    pend_q <= 1'b0;
                end else if (tx_push) begin
                    hold_q <= wr_word;
                    pend_q <= 1'b1;
                end else if (shift_load) begin
                    pend_q <= 1'b0;
                end
            end

            assign tx_full       = pend_q;
            assign tx_empty      = !pend_q;
            assign tx_avail_now  = 1'b1;
            assign tx_avail_next = 1'b1;
            assign tx_word_now   = hold_q;
            assign tx_word_next  = hold_q;
        end else begin : g_tx_fifo
            localparam int TX_CNT_W = $clog2(TX_DEPTH + 1);
            logic [TX_CNT_W-1:0] tx_count;

            spi_buf_fifo #(.W(W), .DEPTH(TX_DEPTH)) u_tx_fifo (
                .clk       (clk),
                .rst       (rst),
                .push      (tx_push),
                .push_data (wr_word),
                .pop       (xfer_ok),
                .head      (tx_word_now),
                .second    (tx_word_next),
                .count     (tx_count),
                .full      (tx_full),
                .empty     (tx_empty)
            );

            assign tx_avail_now  = !tx_empty;
            assign tx_avail_next = (tx_count >= TX_CNT_W'(2));
        end
    endgenerate

    spi_buf_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .avail_now  (tx_avail_now),
        .avail_next (tx_avail_next),
        .done       (eng_done),
        .load       (shift_load),
        .load_next  (load_next),
        .xfer_ok    (xfer_ok)
    );

    assign shift_word = load_next ? tx_word_next : tx_word_now;

    // receive store: double buffer behind the shift register
    spi_buf_fifo #(.W(W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (xfer_ok),
        .push_data (eng_rx_word),
        .pop       (rd_rx),
        .head      (rx_head),
        .second    (rx_second),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign ovr_set = xfer_ok && rx_full;
    assign ovr_clr = wr_st && host_wdata[STAT_OVR];

    always_ff @(posedge clk) begin
        if (rst)          ovr_q <= 1'b0;
        else if (ovr_set) ovr_q <= 1'b1;
        else if (ovr_clr) ovr_q <= 1'b0;
    end

    assign overrun_irq = ovr_q;

    always_comb begin
        status = '0;
        status[STAT_TX_FULL]  = tx_full;
        status[STAT_TX_EMPTY] = tx_empty;
        status[STAT_RX_FULL]  = rx_full;
        status[STAT_RX_EMPTY] = rx_empty;
        status[STAT_OVR]      = ovr_q;
    end

    always_comb begin
        host_rdata = '0;
        host_err   = 1'b0;
        if (host_valid) begin
            unique case (sel)
                REG_TXDATA: host_err = host_write && tx_full;
                REG_RXDATA: begin
                    if (!host_write) begin
                        if (rx_empty) host_err = 1'b1;
                        else          host_rdata = BUS_W'(rx_head) << PAD_W;
                    end
                end
                REG_STATUS: if (!host_write) host_rdata = status;
                REG_NONE:   ;
                default:    ;
            endcase
        end
    end

    assign host_ready  = 1'b1;
    assign unused_bits = ^{host_wdata, rx_second, rx_count};

    // R7: a write into a full transmit store is answered with an error
    a_r7_full_err: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && tx_full) |-> host_err);

    // R8: reading the transmit address yields zero
    a_r8_tx_read_zero: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write && sel == REG_TXDATA) |-> (host_rdata == '0 && !host_err));

    // R9: a completion into a full receive store raises the interrupt
    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (xfer_ok && rx_full) |=> overrun_irq);

    // R10: reading an empty receive store gives error and zero data
    a_r10_rx_empty_err: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && rx_empty) |-> (host_err && host_rdata == '0));

    // R11: the interrupt stays set unless cleared by the host
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun_irq && !ovr_clr) |=> overrun_irq);

endmodule

// File: tb/spi_xfer_buffer_tb.sv
module spi_xfer_buffer_tb;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        hv  [2];
    logic        hw  [2];
    logic [1:0]  ha  [2];
    logic [31:0] hwd [2];
    logic        hrdy[2];
    logic [31:0] hr  [2];
    logic        he  [2];
    logic        em  [2];
    logic        een [2];
    logic        ess [2];
    logic        edn [2];
    logic [W-1:0] erx[2];
    logic        ld  [2];
    logic [W-1:0] lw [2];
    logic        irq [2];

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    spi_xfer_buffer #(.W(W), .TX_DEPTH(1), .RX_DEPTH(1)) u_dut (
        .clk(clk), .rst(rst),
        .host_valid(hv[0]), .host_write(hw[0]), .host_addr(ha[0]), .host_wdata(hwd[0]),
        .host_ready(hrdy[0]), .host_rdata(hr[0]), .host_err(he[0]),
        .eng_master(em[0]), .eng_enable(een[0]), .eng_ssel(ess[0]),
        .eng_done(edn[0]), .eng_rx_word(erx[0]),
        .shift_load(ld[0]), .shift_word(lw[0]), .overrun_irq(irq[0])
    );

    spi_xfer_buffer #(.W(W), .TX_DEPTH(4), .RX_DEPTH(2)) u_dut_fifo (
        .clk(clk), .rst(rst),
        .host_valid(hv[1]), .host_write(hw[1]), .host_addr(ha[1]), .host_wdata(hwd[1]),
        .host_ready(hrdy[1]), .host_rdata(hr[1]), .host_err(he[1]),
        .eng_master(em[1]), .eng_enable(een[1]), .eng_ssel(ess[1]),
        .eng_done(edn[1]), .eng_rx_word(erx[1]),
        .shift_load(ld[1]), .shift_word(lw[1]), .overrun_irq(irq[1])
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one host access; response sampled in its own cycle
    task automatic acc(input int d, input logic wr, input logic [1:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        hv[d] = 1'b1; hw[d] = wr; ha[d] = a; hwd[d] = wd;
        #1;
        rd = hr[d]; er = he[d];
        @(posedge clk);
        #1;
        hv[d] = 1'b0; hw[d] = 1'b0;
    endtask

    // one completion pulse; load sampled in the same cycle
    task automatic xdone(input int d, input logic [W-1:0] word, output logic l, output logic [W-1:0] lword);
        @(negedge clk);
        edn[d] = 1'b1; erx[d] = word;
        #1;
        l = ld[d]; lword = lw[d];
        @(posedge clk);
        #1;
        edn[d] = 1'b0;
    endtask

    // change go inputs; load sampled in the same cycle
    task automatic setgo(input int d, input logic m, input logic en, input logic ss,
                         output logic l, output logic [W-1:0] lword);
        @(negedge clk);
        em[d] = m; een[d] = en; ess[d] = ss;
        #1;
        l = ld[d]; lword = lw[d];
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] top(input logic [W-1:0] v);
        return {v, {(32-W){1'b0}}};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er, l;
        logic [W-1:0] lword;
        for (int d = 0; d < 2; d++) begin
            hv[d] = 0; hw[d] = 0; ha[d] = 0; hwd[d] = 0;
            em[d] = 0; een[d] = 0; ess[d] = 0; edn[d] = 0; erx[d] = 0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // ---------------- single register configuration ----------------
        acc(0, 0, 2'd2, 0, rd, er);      chk("R2 reset status", rd, 32'h0A);
        chk("R2 reset irq", {31'b0, irq[0]}, 0);
        chk("R3 no load after reset", {31'b0, ld[0]}, 0);
        acc(0, 1, 2'd0, top(8'hA5), rd, er); chk("R1 tx write accepted", {31'b0, er}, 0);
        acc(0, 0, 2'd2, 0, rd, er);      chk("R12 status tx full", rd, 32'h09);
        acc(0, 1, 2'd0, top(8'h5A), rd, er); chk("R7 write when full errs", {31'b0, er}, 1);
        acc(0, 0, 2'd0, 0, rd, er);      chk("R8 tx read zero", {rd[31:1], er}, 0);
        setgo(0, 0, 1, 0, l, lword);     chk("R3 slave without select no load", {31'b0, l}, 0);
        xdone(0, 8'h77, l, lword);
        acc(0, 0, 2'd2, 0, rd, er);      chk("R13 idle done ignored", rd, 32'h09);
        setgo(0, 0, 1, 1, l, lword);     chk("R3 slave select starts", {31'b0, l}, 1);
        chk("R7 stored word unchanged", {24'b0, lword}, 32'hA5);
        acc(0, 0, 2'd2, 0, rd, er);      chk("R5 load clears full", rd, 32'h0A);
        xdone(0, 8'h3C, l, lword);       chk("R5 resend load", {31'b0, l}, 1);
        chk("R5 resend word", {24'b0, lword}, 32'hA5);
        acc(0, 0, 2'd1, 0, rd, er);      chk("R1 rx read placement", rd, top(8'h3C));
        chk("R9 rx read no error", {31'b0, er}, 0);
        acc(0, 0, 2'd1, 0, rd, er);      chk("R10 empty read errs", {31'b0, er}, 1);
        chk("R10 empty read zero", rd, 0);
        acc(0, 1, 2'd1, top(8'hFF), rd, er); chk("R10 rx write no error", {31'b0, er}, 0);
        acc(0, 0, 2'd2, 0, rd, er);      chk("R10 rx write ignored", rd, 32'h0A);
        xdone(0, 8'h11, l, lword);
        chk("R9 no overrun yet", {31'b0, irq[0]}, 0);
        xdone(0, 8'h22, l, lword);
        chk("R9 overrun raised", {31'b0, irq[0]}, 1);
        acc(0, 0, 2'd1, 0, rd, er);      chk("R9 older word kept", rd, top(8'h11));
        chk("R11 irq sticky after read", {31'b0, irq[0]}, 1);
        acc(0, 1, 2'd2, 32'h0F, rd, er); chk("R11 write bit4 clear keeps", {31'b0, irq[0]}, 1);
        acc(0, 1, 2'd2, 32'h10, rd, er); chk("R11 clear by write one", {31'b0, irq[0]}, 0);
        acc(0, 1, 2'd0, top(8'hC3), rd, er);
        setgo(0, 0, 1, 0, l, lword);
        xdone(0, 8'h44, l, lword);       chk("R4 no chain without go", {31'b0, l}, 0);
        setgo(0, 0, 1, 1, l, lword);     chk("R4 idle after stop, restart", {31'b0, l}, 1);
        chk("R5 new word sent", {24'b0, lword}, 32'hC3);

        // ---------------- FIFO configuration ----------------
        acc(1, 0, 2'd2, 0, rd, er);      chk("R2 fifo reset status", rd, 32'h0A);
        for (int i = 1; i <= 4; i++) begin
            acc(1, 1, 2'd0, top(8'(i * 8'h11)), rd, er);
            chk("R6 fifo write accepted", {31'b0, er}, 0);
        end
        acc(1, 1, 2'd0, top(8'h55), rd, er); chk("R7 fifo full errs", {31'b0, er}, 1);
        setgo(1, 1, 0, 1, l, lword);     chk("R3 master ignores select", {31'b0, l}, 0);
        setgo(1, 1, 1, 1, l, lword);     chk("R3 master enable starts", {31'b0, l}, 1);
        chk("R6 head word first", {24'b0, lword}, 32'h11);
        acc(1, 0, 2'd2, 0, rd, er);      chk("R6 count kept until done", rd, 32'h09);
        for (int i = 2; i <= 4; i++) begin
            xdone(1, 8'(8'hA0 + i - 1), l, lword);
            chk("R4 chained load", {31'b0, l}, 1);
            chk("R6 next entry word", {24'b0, lword}, 32'(i * 8'h11));
        end
        chk("R9 fifo overrun", {31'b0, irq[1]}, 1);
        setgo(1, 1, 0, 1, l, lword);
        xdone(1, 8'hA4, l, lword);       chk("R4 stop without enable", {31'b0, l}, 0);
        acc(1, 0, 2'd2, 0, rd, er);      chk("R12 fifo status", rd, 32'h16);
        acc(1, 0, 2'd1, 0, rd, er);      chk("R9 fifo first word", rd, top(8'hA1));
        acc(1, 0, 2'd1, 0, rd, er);      chk("R9 fifo second word", rd, top(8'hA2));
        acc(1, 0, 2'd1, 0, rd, er);      chk("R10 fifo drained errs", {31'b0, er}, 1);
        chk("R10 host_ready", {31'b0, hrdy[1]}, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule